// File: doc/BRIEF.md
# Oscillator Stabilization Counter Controller

This block decides when an external crystal oscillator may be trusted as a clock source. Once the oscillator is switched on, a stabilization counter runs. When the counter reaches a programmable terminal value, the block reports the oscillator as stable and raises a pending flag. The terminal value is an 8-bit end-of-count field multiplied by 512. Software clears the flag by writing 1 to it, and a separate mask bit decides whether the flag drives the interrupt request.

The same 32-bit control/status word holds a sticky bypass bit. Software can set this bit but can never clear it; only a system reset returns it to 0. While the bit is set, the root clock select points at the external input pin instead of the oscillator output, and the stabilization counter is held cleared.

Software reaches the word over a plain register bus. A write is accepted only when it comes from supervisor mode and hits the register's address. Reads are combinational. The register uses big-endian bit numbering: bit 0 is the MSB, carried on `bus_wdata[31]`.

Top module: `osc_stab_ctrl`

## Requirements
- R1: After reset the register reads 0x00800000: the end-of-count field holds 0x80 and every other field is 0. `root_sel`, `irq` and `osc_stable` are all 0.
- R2: The fields sit at fixed positions, given here in LSB-0 data bits:
  - bypass is data[31] (bit 0 in big-endian numbering);
  - end-of-count is data[23:16] (bits 8–15);
  - mask is data[15] (bit 16);
  - pending is data[7] (bit 24).
  All other bits read 0.
- R3: A count starts from zero on the first clock edge at which `osc_on` is 1. The pending flag and `osc_stable` become 1 on the (EOC×512+1)-th consecutive edge with `osc_on` high, and not before.
- R4: With an end-of-count value of 0, pending and `osc_stable` are set on the first edge after `osc_on` rises.
- R5: After reaching its terminal value the counter saturates. `osc_stable` stays 1, and a cleared pending flag is not set again while `osc_on` stays high.
- R6: Writing 1 to data[7] clears the pending flag. Writing 0 there leaves the flag unchanged.
- R7: `irq` is 1 exactly when both pending and mask are 1. A mask of 0 suppresses `irq`.
- R8: A write with data[31]=1 sets bypass, which drives `root_sel` to 1. A later write with data[31]=0 leaves it at 1, and only `rst` clears it.
- R9: While bypass is 1 the counter is held cleared. `osc_stable` stays 0 and pending is not set by the counter.
- R10: Writes with `bus_super`=0 change no field.
- R11: If the counter sets pending on the same edge as a write-1 clear, pending ends up 1.
- R12: `osc_on` going low clears the count. A new rising edge restarts the count from zero.
- R13: Accesses at any address other than `REG_ADDR` read 0 and change no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one full 32-bit word |
| bus_super | input | 1 | 1 = supervisor access, 0 = user access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| osc_on | input | 1 | Oscillator enabled |
| irq | output | 1 | Oscillator-available interrupt request |
| osc_stable | output | 1 | Stabilization count complete |
| root_sel | output | 1 | 1 = external pin is the root clock, 0 = oscillator output |

## Verification
Every write reaches the register on the clock edge that samples it, and read data is combinational. The bench therefore drives on falling edges and reads half a cycle after the edge that wrote. Pending, `irq` and `osc_stable` change on edge EOC×512+1 counted from the first edge with `osc_on` high. The bench counts falling edges from that point and checks on both sides of that edge: after EOC×512 edges nothing may be set, and after one more edge it must be. For the collision case, the bench raises `osc_on` and issues the clearing write in the same half cycle, so both land on the same edge.

// File: rtl/osc_stab_pkg.sv
package osc_stab_pkg;
    localparam int DATA_W     = 32;
    localparam int EOC_W      = 8;
    localparam int SCALE_LOG2 = 9;
    localparam int CNT_W      = EOC_W + SCALE_LOG2;

    // LSB-0 positions of the big-endian-numbered fields
    localparam int POS_BYP  = 31;
    localparam int POS_EOC  = 16;
    localparam int POS_MASK = 15;
    localparam int POS_PEND = 7;

    localparam logic [EOC_W-1:0] EOC_RESET = 8'h80;

    typedef struct packed {
        logic             bypass;
        logic [EOC_W-1:0] eoc;
        logic             mask;
        logic             pend;
    } ctl_fields_t;

    function automatic logic [DATA_W-1:0] pack_fields(ctl_fields_t f);
        logic [DATA_W-1:0] w;
        w = '0;
        w[POS_BYP]                    = f.bypass;
        w[POS_EOC +: EOC_W]           = f.eoc;
        w[POS_MASK]                   = f.mask;
        w[POS_PEND]                   = f.pend;
        return w;
    endfunction

    function automatic logic [CNT_W-1:0] term_of(logic [EOC_W-1:0] eoc);
        return {eoc, {SCALE_LOG2{1'b0}}};
    endfunction
endpackage

// File: rtl/osc_stab_regs.sv
module osc_stab_regs
    import osc_stab_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hw_set,
    output ctl_fields_t       fields
);
    ctl_fields_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q.bypass <= 1'b0;
            q.eoc    <= EOC_RESET;
            q.mask   <= 1'b0;
            q.pend   <= 1'b0;
        end else begin
            if (wr_en) begin
                q.bypass <= q.bypass | wdata[POS_BYP];
                q.eoc    <= wdata[POS_EOC +: EOC_W];
                q.mask   <= wdata[POS_MASK];
            end
            if (hw_set)
                q.pend <= 1'b1;
            else if (wr_en && wdata[POS_PEND])
                q.pend <= 1'b0;
        end
    end

    assign fields = q;

    // R8: bypass never falls except by reset
    a_r8_bypass_sticky: assert property (@(posedge clk) disable iff (rst)
        q.bypass |=> q.bypass);
    // R6: without a clearing write, pending holds
    a_r6_pend_holds: assert property (@(posedge clk) disable iff (rst)
        (q.pend && !(wr_en && wdata[POS_PEND])) |=> q.pend);
    // R3: pending rises only from a counter hit
    a_r3_pend_from_hw: assert property (@(posedge clk) disable iff (rst)
        !q.pend ##1 q.pend |-> $past(hw_set));
    // R11: hardware set beats a clear
    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
        hw_set |=> q.pend);
endmodule

// File: rtl/osc_stab_counter.sv
module osc_stab_counter
    import osc_stab_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_on,
    input  logic             hold,
    input  logic [EOC_W-1:0] eoc,
    output logic             hit,
    output logic             done
);
    logic [CNT_W-1:0] cnt;
    logic             run;

    assign run = osc_on && !hold && !done;
    assign hit = run && (cnt >= term_of(eoc));

    always_ff @(posedge clk) begin
        if (rst || !osc_on || hold) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (hit) begin
            done <= 1'b1;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R9: bypass holds the counter cleared
    a_r9_hold_clears: assert property (@(posedge clk) disable iff (rst)
        hold |=> (cnt == '0 && !done));
    // R5: done saturates while enabled
    a_r5_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (done && osc_on && !hold) |=> (done && $stable(cnt)));
    // R12: oscillator off clears the count
    a_r12_off_clears: assert property (@(posedge clk) disable iff (rst)
        !osc_on |=> (cnt == '0 && !done));
    // R5: no second hit after saturation
    a_r5_single_hit: assert property (@(posedge clk) disable iff (rst)
        done |-> !hit);
endmodule

// File: rtl/osc_stab_ctrl.sv
module osc_stab_ctrl
    import osc_stab_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int REG_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_super,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              osc_on,
    output logic              irq,
    output logic              osc_stable,
    output logic              root_sel
);
    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(REG_ADDR);

    logic        addr_hit;
    logic        wr_ok;
    logic        cnt_hit;
    ctl_fields_t f;

    assign addr_hit = (bus_addr == SEL_ADDR);
    assign wr_ok    = bus_wr && bus_super && addr_hit;

    osc_stab_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_ok),
        .wdata  (bus_wdata),
        .hw_set (cnt_hit),
        .fields (f)
    );

    osc_stab_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .osc_on (osc_on),
        .hold   (f.bypass),
        .eoc    (f.eoc),
        .hit    (cnt_hit),
        .done   (osc_stable)
    );

    assign bus_rdata = addr_hit ? pack_fields(f) : '0;
    assign irq       = f.pend & f.mask;
    assign root_sel  = f.bypass;

    // R10: user-mode writes leave configuration untouched
    a_r10_user_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_super) |=> ($stable(f.eoc) && $stable(f.mask) && $stable(f.bypass)));
    // R13: foreign addresses leave configuration untouched
    a_r13_addr_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !addr_hit) |=> ($stable(f.eoc) && $stable(f.mask) && $stable(f.bypass)));
    // R9: no stability while bypassed
    a_r9_no_stable_bypass: assert property (@(posedge clk) disable iff (rst)
        root_sel |=> !osc_stable);
endmodule

// File: tb/osc_stab_ctrl_test.sv
module osc_stab_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_super = 1'b1;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        osc_on = 1'b0;
    logic        irq, osc_stable, root_sel;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    osc_stab_ctrl uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_super(bus_super), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .osc_on(osc_on), .irq(irq), .osc_stable(osc_stable), .root_sel(root_sel)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic edges(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d, logic sup);
        bus_addr = a; bus_wdata = d; bus_super = sup; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_super = 1'b1; bus_addr = '0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata; bus_addr = '0;
    endtask

    task automatic idle_clear();
        osc_on = 1'b0;
        edges(2);
        wr(0, 32'h0000_0080, 1'b1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(0, d);
        chk("R1 reset word", d, 32'h0080_0000);
        chk("R1 outputs", {29'd0, root_sel, irq, osc_stable}, 32'd0);
    endtask

    task automatic t_layout();
        logic [31:0] d;
        wr(0, 32'h7F5A_FF7F, 1'b1);
        rd(0, d);
        chk("R2 field positions", d, 32'h005A_8000);
        idle_clear();
    endtask

    task automatic t_count();
        logic [31:0] d;
        wr(0, 32'h0001_8000, 1'b1);
        osc_on = 1'b1;
        edges(512);
        rd(0, d);
        chk("R3 pending early", d, 32'h0001_8000);
        chk("R3 stable early", {31'd0, osc_stable}, 32'd0);
        edges(1);
        rd(0, d);
        chk("R3 pending at term", d, 32'h0001_8080);
        chk("R3 stable at term", {31'd0, osc_stable}, 32'd1);
        chk("R7 irq with mask", {31'd0, irq}, 32'd1);
        idle_clear();
    endtask

    task automatic t_zero_sat();
        logic [31:0] d;
        wr(0, 32'h0000_8000, 1'b1);
        osc_on = 1'b1;
        edges(1);
        rd(0, d);
        chk("R4 eoc zero first edge", d, 32'h0000_8080);
        wr(0, 32'h0000_8000, 1'b1);
        rd(0, d);
        chk("R6 write zero keeps", d, 32'h0000_8080);
        wr(0, 32'h0000_0080, 1'b1);
        rd(0, d);
        chk("R6 write one clears", d, 32'h0000_0000);
        edges(50);
        rd(0, d);
        chk("R5 no re-set", d, 32'h0000_0000);
        chk("R5 stable held", {31'd0, osc_stable}, 32'd1);
        idle_clear();
    endtask

    task automatic t_mask();
        wr(0, 32'h0000_0000, 1'b1);
        osc_on = 1'b1;
        edges(2);
        chk("R7 masked irq", {31'd0, irq}, 32'd0);
        wr(0, 32'h0000_8000, 1'b1);
        chk("R7 unmasked irq", {31'd0, irq}, 32'd1);
        idle_clear();
    endtask

    task automatic t_restart();
        logic [31:0] d;
        wr(0, 32'h0001_0000, 1'b1);
        osc_on = 1'b1;
        edges(300);
        osc_on = 1'b0;
        edges(1);
        osc_on = 1'b1;
        edges(512);
        rd(0, d);
        chk("R12 restarted count", d, 32'h0001_0000);
        edges(1);
        rd(0, d);
        chk("R12 hit after restart", d, 32'h0001_0080);
        idle_clear();
    endtask

    task automatic t_collide();
        logic [31:0] d;
        osc_on = 1'b1;
        wr(0, 32'h0000_8080, 1'b1);
        rd(0, d);
        chk("R11 set beats clear", d, 32'h0000_8080);
        idle_clear();
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        wr(0, 32'h0033_8000, 1'b1);
        wr(0, 32'h80FF_0000, 1'b0);
        rd(0, d);
        chk("R10 user write", d, 32'h0033_8000);
        chk("R10 root_sel", {31'd0, root_sel}, 32'd0);
        wr(4'd3, 32'h80FF_0000, 1'b1);
        rd(0, d);
        chk("R13 foreign write", d, 32'h0033_8000);
        rd(4'd3, d);
        chk("R13 foreign read", d, 32'h0);
    endtask

    task automatic t_bypass();
        logic [31:0] d;
        wr(0, 32'h8000_8000, 1'b1);
        chk("R8 root_sel set", {31'd0, root_sel}, 32'd1);
        osc_on = 1'b1;
        edges(10);
        rd(0, d);
        chk("R9 no pending", d, 32'h8000_8000);
        chk("R9 no stable", {31'd0, osc_stable}, 32'd0);
        wr(0, 32'h0000_8000, 1'b1);
        rd(0, d);
        chk("R8 bypass sticky", d, 32'h8000_8000);
        osc_on = 1'b0;
        rst = 1'b1;
        edges(1);
        rst = 1'b0;
        rd(0, d);
        chk("R8 reset clears", d, 32'h0080_0000);
        chk("R8 root_sel cleared", {31'd0, root_sel}, 32'd0);
    endtask

    initial begin
        edges(3);
        rst = 1'b0;
        t_reset();
        t_layout();
        t_count();
        t_zero_sat();
        t_mask();
        t_restart();
        t_collide();
        t_ignored();
        t_bypass();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule